// File: doc/BRIEF.md
# Bit-band alias translator

This block sits between a CPU-side request port and a memory port. It watches every request for an address inside one of two alias windows. One window covers SRAM and the other covers peripheral registers. Each aligned 32-bit word in an alias window stands for exactly one bit of one word in the matching region. The block turns an alias access into an operation on that single bit. An alias read returns the bit in bit 0 of the read data. An alias write becomes a locked read-modify-write that changes only the targeted bit.

Translation is granted only to the CPU master. When any other master, such as a DMA engine, touches an alias window, it gets an error response and memory is left untouched. Addresses outside both windows go straight through in the same cycle, whichever master issues them. The requester keeps its request, address and data steady until it sees ready high.

The sequencer has three states:

- `ST_IDLE` decodes the request. Pass-through accesses, alias reads and error responses all complete here. An alias write from the CPU (transition *start*) issues the locked read and moves to `ST_MODIFY`.
- `ST_MODIFY` always moves on (transition *commit*). It issues the locked write of the merged word and moves to `ST_FINISH`.
- `ST_FINISH` always moves on (transition *release*). It raises ready with no downstream access and returns to `ST_IDLE`.

Top module: `bitband_xlate`

## Requirements
- R1: A request whose address is outside both alias windows is copied to the memory port in the same cycle. Request, write enable, address and write data are copied unchanged, read data comes back combinationally, ready is 1, error is 0 and lock is 0.
- R2: An address A with A[31:25] = 7'b0010001 (window 0x2200_0000 to 0x23FF_FFFC) targets word 0x2000_0000 + 4*A[24:7] at bit A[6:2].
- R3: An address A with A[31:25] = 7'b0100001 (window 0x4200_0000 to 0x43FF_FFFC) targets word 0x4000_0000 + 4*A[24:7] at bit A[6:2].
- R4: A CPU alias read performs one downstream read of the target word. It completes in the same cycle and returns the target bit in data bit 0, with bits 31:1 equal to 0.
- R5: A CPU alias write takes three cycles. In the first cycle there is a downstream read of the target word. In the second cycle there is a downstream write to the same address. Lock is 1 in both of these cycles and ready is 0 in both. In the third cycle ready is 1 and there is no downstream request.
- R6: The word written in an alias write equals the word that was read, with only the target bit replaced by bit 0 of the upstream write data.
- R7: A request to an alias window from a master whose ID is not 0 (CPU ID 0) completes in one cycle. It gets error 1 and read data 0, and it makes no downstream request, so memory is unchanged.
- R8: A request from a master other than the CPU outside the alias windows passes through exactly as in R1.
- R9: After reset, with no request pending, ready is 1, the downstream request is 0 and lock is 0.
- R10: In the cycle after an alias write completes, a new request is accepted and served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream request, held until ready |
| up_we | input | 1 | Upstream write enable |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data |
| up_master | input | 2 | ID of the requesting master, 0 is the CPU |
| up_ready | output | 1 | Access completes this cycle |
| up_rdata | output | 32 | Upstream read data |
| up_err | output | 1 | Error response |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream write enable |
| dn_lock | output | 1 | Downstream locked-sequence indicator |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, same-cycle |

## Verification
The bench targets the edges of both windows: the last alias word of the SRAM window (bit 31 of the top word) and the word just below that window. A decoder with an off-by-one window compare would either corrupt memory with a bit write or return a single bit where a whole word was expected. It sets and clears bits whose neighbours have mixed values, so a wrong bit index or a wrong merge mask shows up as altered neighbouring bits on read-back. It sends alias accesses from the DMA master and then reads the target through pass-through, which exposes a design that writes memory anyway or raises no error. It follows a write cycle by cycle and then issues a request back-to-back, which catches ready rising early, lock dropping between the read and the write, or a sequencer that re-triggers on the request still held high.

// File: rtl/bb_pkg.sv
package bb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MODIFY = 2'd1,
        ST_FINISH = 2'd2
    } bb_state_e;
endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
    parameter int ADDR_W                  = 32,
    parameter int DATA_W                  = 32,
    parameter int WIN_BITS                = 25,
    parameter logic [ADDR_W-1:0] ALIAS_AT = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] REGION_AT = 32'h2000_0000
) (
    input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] word_addr,
    output logic                               hit,
    output logic [ADDR_W-1:0]                  target,
    output logic [$clog2(DATA_W)-1:0]          bit_sel
);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int TOP_W   = ADDR_W - BYTE_SH;
    localparam int IDX_W   = WIN_BITS - BYTE_SH - BIT_W;
    localparam int CMP_LO  = WIN_BITS - BYTE_SH;

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        hit      = (word_addr[TOP_W-1:CMP_LO] == ALIAS_AT[ADDR_W-1:WIN_BITS]);
        word_idx = word_addr[CMP_LO-1:BIT_W];
        bit_sel  = word_addr[BIT_W-1:0];
        target   = REGION_AT + ADDR_W'({word_idx, {BYTE_SH{1'b0}}});
    end
endmodule

// File: rtl/bb_bit_pick.sv
module bb_bit_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         word,
    input  logic [$clog2(DATA_W)-1:0] bit_sel,
    output logic [DATA_W-1:0]         result
);
    always_comb begin
        result    = '0;
        result[0] = word[bit_sel];
    end
endmodule

// File: rtl/bb_bit_set.sv
module bb_bit_set #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         word,
    input  logic [$clog2(DATA_W)-1:0] bit_sel,
    input  logic                      value,
    output logic [DATA_W-1:0]         result
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask   = DATA_W'(1) << bit_sel;
        result = value ? (word | mask) : (word & ~mask);
    end
endmodule

// File: rtl/bb_seq.sv
module bb_seq
    import bb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic cap_en,
    output logic in_modify,
    output logic in_finish
);
    bb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cap_en    = 1'b0;
        in_modify = 1'b0;
        in_finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cap_en  = 1'b1;
                    state_d = ST_MODIFY;
                end
            end
            ST_MODIFY: begin
                in_modify = 1'b1;
                state_d   = ST_FINISH;
            end
            ST_FINISH: begin
                in_finish = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MID_W    = 2,
    parameter logic [MID_W-1:0] CPU_ID = '0,
    parameter int WIN_BITS = 25,
    parameter int N_REG    = 2,
    parameter logic [N_REG-1:0][ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [N_REG-1:0][ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [MID_W-1:0]  up_master,
    output logic              up_ready,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_err,
    output logic              dn_req,
    output logic              dn_we,
    output logic              dn_lock,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata
);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam int BIT_W   = $clog2(DATA_W);

    logic [N_REG-1:0]             reg_hit;
    logic [ADDR_W-1:0]            reg_tgt [N_REG];
    logic [BIT_W-1:0]             reg_bit [N_REG];

    logic                         alias_hit;
    logic [ADDR_W-1:0]            dec_tgt;
    logic [BIT_W-1:0]             dec_bit;
    logic                         is_cpu;
    logic                         start;
    logic                         cap_en, in_modify, in_finish;

    logic [DATA_W-1:0]            word_q;
    logic [ADDR_W-1:0]            tgt_q;
    logic [BIT_W-1:0]             bit_q;
    logic                         val_q;
    logic [DATA_W-1:0]            picked;
    logic [DATA_W-1:0]            merged;

    for (genvar r = 0; r < N_REG; r++) begin : g_region
        bb_alias_decode #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .WIN_BITS (WIN_BITS),
            .ALIAS_AT (ALIAS_BASES[r]),
            .REGION_AT(REGION_BASES[r])
        ) i_dec (
            .word_addr(up_addr[ADDR_W-1:BYTE_SH]),
            .hit      (reg_hit[r]),
            .target   (reg_tgt[r]),
            .bit_sel  (reg_bit[r])
        );
    end

    always_comb begin
        dec_tgt = '0;
        dec_bit = '0;
        for (int r = 0; r < N_REG; r++) begin
            if (reg_hit[r]) begin
                dec_tgt = reg_tgt[r];
                dec_bit = reg_bit[r];
            end
        end
    end

    assign alias_hit = |reg_hit;
    assign is_cpu    = (up_master == CPU_ID);
    assign start     = up_req && alias_hit && is_cpu && up_we;

    bb_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cap_en   (cap_en),
        .in_modify(in_modify),
        .in_finish(in_finish)
    );

    bb_bit_pick #(.DATA_W(DATA_W)) i_pick (
        .word   (dn_rdata),
        .bit_sel(dec_bit),
        .result (picked)
    );

    bb_bit_set #(.DATA_W(DATA_W)) i_set (
        .word   (word_q),
        .bit_sel(bit_q),
        .value  (val_q),
        .result (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            tgt_q  <= '0;
            bit_q  <= '0;
            val_q  <= 1'b0;
        end else if (cap_en) begin
            word_q <= dn_rdata;
            tgt_q  <= dec_tgt;
            bit_q  <= dec_bit;
            val_q  <= up_wdata[0];
        end
    end

    always_comb begin
        up_ready = 1'b1;
        up_rdata = '0;
        up_err   = 1'b0;
        dn_req   = 1'b0;
        dn_we    = 1'b0;
        dn_lock  = 1'b0;
        dn_addr  = up_addr;
        dn_wdata = up_wdata;
        if (in_modify) begin
            up_ready = 1'b0;
            dn_req   = 1'b1;
            dn_we    = 1'b1;
            dn_lock  = 1'b1;
            dn_addr  = tgt_q;
            dn_wdata = merged;
        end else if (in_finish) begin
            up_ready = 1'b1;
        end else if (up_req) begin
            if (!alias_hit) begin
                dn_req   = 1'b1;
                dn_we    = up_we;
                up_rdata = dn_rdata;
            end else if (!is_cpu) begin
                up_err = 1'b1;
            end else if (!up_we) begin
                dn_req   = 1'b1;
                dn_addr  = dec_tgt;
                up_rdata = picked;
            end else begin
                up_ready = 1'b0;
                dn_req   = 1'b1;
                dn_lock  = 1'b1;
                dn_addr  = dec_tgt;
            end
        end
    end
endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_ready,
    input logic              up_err,
    input logic              dn_req,
    input logic              dn_we,
    input logic              dn_lock,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [DATA_W-1:0] dn_wdata,
    input logic [DATA_W-1:0] dn_rdata
);
    AST_LOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_lock |-> !up_ready); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_lock && !dn_we) |=> (dn_req && dn_we && dn_lock)); // R5
    AST_SAME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_lock && !dn_we) |=> (dn_addr == $past(dn_addr))); // R5
    AST_WRITE_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_lock && dn_we) |=> (up_ready && !dn_req && !dn_lock)); // R5
    AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_lock && dn_we) |-> ($countones(dn_wdata ^ $past(dn_rdata)) <= 1)); // R6
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> (!dn_req && up_ready)); // R7
endmodule

bind bitband_xlate bb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_ready(up_ready),
    .up_err  (up_err),
    .dn_req  (dn_req),
    .dn_we   (dn_we),
    .dn_lock (dn_lock),
    .dn_addr (dn_addr),
    .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
);

// File: tb/test_bitband_xlate.sv
module test_bitband_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req = 1'b0, up_we = 1'b0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic [1:0]  up_master = '0;
    logic        up_ready, up_err, dn_req, dn_we, dn_lock;
    logic [31:0] up_rdata, dn_addr, dn_wdata, dn_rdata;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    bitband_xlate i_bitband_xlate (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we),
        .up_addr(up_addr), .up_wdata(up_wdata), .up_master(up_master),
        .up_ready(up_ready), .up_rdata(up_rdata), .up_err(up_err),
        .dn_req(dn_req), .dn_we(dn_we), .dn_lock(dn_lock),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Memory model: sparse map folded onto 128 words
    logic [31:0] mem [0:127];
    function automatic logic [6:0] slot(input logic [31:0] a);
        return {a[30], a[29], a[6:2]};
    endfunction
    assign dn_rdata = mem[slot(dn_addr)];
    always @(posedge clk) if (dn_req && dn_we) mem[slot(dn_addr)] <= dn_wdata;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  mid;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [1:0]  exp_cyc;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 32'h2000_0004, 32'h1234_5678, 1'b0, 32'h0,         1'b0, 2'd1}, // R1 write
        '{2'd0, 1'b0, 32'h2000_0004, 32'h0,         1'b1, 32'h1234_5678, 1'b0, 2'd1}, // R1 read
        '{2'd0, 1'b1, 32'h2200_0080, 32'h0000_0001, 1'b0, 32'h0,         1'b0, 2'd3}, // R2 set bit0
        '{2'd0, 1'b0, 32'h2000_0004, 32'h0,         1'b1, 32'h1234_5679, 1'b0, 2'd1}, // R6
        '{2'd0, 1'b1, 32'h2200_00F0, 32'hFFFF_FFFE, 1'b0, 32'h0,         1'b0, 2'd3}, // R6 clear bit28
        '{2'd0, 1'b0, 32'h2000_0004, 32'h0,         1'b1, 32'h0234_5679, 1'b0, 2'd1}, // R6
        '{2'd0, 1'b0, 32'h2200_00F0, 32'h0,         1'b1, 32'h0000_0000, 1'b0, 2'd1}, // R4
        '{2'd0, 1'b0, 32'h2200_0080, 32'h0,         1'b1, 32'h0000_0001, 1'b0, 2'd1}, // R4
        '{2'd0, 1'b1, 32'h4000_0010, 32'h0,         1'b0, 32'h0,         1'b0, 2'd1}, // R1
        '{2'd0, 1'b1, 32'h4200_0214, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0, 2'd3}, // R3
        '{2'd0, 1'b0, 32'h4000_0010, 32'h0,         1'b1, 32'h0000_0020, 1'b0, 2'd1}, // R3
        '{2'd0, 1'b0, 32'h4200_0214, 32'h0,         1'b1, 32'h0000_0001, 1'b0, 2'd1}, // R3 R4
        '{2'd1, 1'b1, 32'h4200_0214, 32'h0,         1'b1, 32'h0,         1'b1, 2'd1}, // R7
        '{2'd0, 1'b0, 32'h4000_0010, 32'h0,         1'b1, 32'h0000_0020, 1'b0, 2'd1}, // R7 untouched
        '{2'd2, 1'b0, 32'h2200_0080, 32'h0,         1'b1, 32'h0,         1'b1, 2'd1}, // R7 read
        '{2'd1, 1'b0, 32'h4000_0010, 32'h0,         1'b1, 32'h0000_0020, 1'b0, 2'd1}, // R8
        '{2'd0, 1'b1, 32'h200F_FFFC, 32'h0,         1'b0, 32'h0,         1'b0, 2'd1}, // R2 edge
        '{2'd0, 1'b1, 32'h23FF_FFFC, 32'h0000_0001, 1'b0, 32'h0,         1'b0, 2'd3}, // R2 top
        '{2'd0, 1'b0, 32'h200F_FFFC, 32'h0,         1'b1, 32'h8000_0000, 1'b0, 2'd1}, // R2
        '{2'd0, 1'b0, 32'h21FF_FFFC, 32'h0,         1'b1, 32'h8000_0000, 1'b0, 2'd1}  // R1 below window
    };

    task automatic access(input vec_t v, output logic [31:0] rd, output logic er, output int cyc);
        @(negedge clk);
        up_req = 1'b1; up_we = v.we; up_addr = v.addr; up_wdata = v.wdata; up_master = v.mid;
        cyc = 0;
        forever begin
            #1;
            cyc++;
            if (up_ready || cyc > 8) begin
                rd = up_rdata; er = up_err;
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1 up_req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'hA5A5_0000 + i;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(up_ready === 1'b1, "R9 ready", {31'b0, up_ready}, 32'h1);
        chk(dn_req === 1'b0 && dn_lock === 1'b0, "R9 idle", {30'b0, dn_req, dn_lock}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(up_ready === 1'b1 && dn_req === 1'b0, "R9 after release", {30'b0, up_ready, dn_req}, 32'h2);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] rd;
            logic er;
            int cyc;
            access(VECS[i], rd, er, cyc);
            chk(cyc == int'(VECS[i].exp_cyc), $sformatf("R1/R5 cycles vec%0d", i), cyc, VECS[i].exp_cyc);
            chk(er === VECS[i].exp_err, $sformatf("R7 error vec%0d", i), {31'b0, er}, {31'b0, VECS[i].exp_err});
            if (VECS[i].chk_rd)
                chk(rd === VECS[i].exp_rd, $sformatf("R2/R3/R4/R6 data vec%0d", i), rd, VECS[i].exp_rd);
        end

        // R5 cycle-by-cycle: set bit1 of word 0x2000_0004 (0x0234_5679)
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b1; up_addr = 32'h2200_0084; up_wdata = 32'h1; up_master = 2'd0;
        #1;
        chk(dn_req && !dn_we && dn_lock && !up_ready, "R5 read phase", {28'b0, dn_req, dn_we, dn_lock, up_ready}, 32'hA);
        chk(dn_addr === 32'h2000_0004, "R2 target addr", dn_addr, 32'h2000_0004);
        @(negedge clk); #1;
        chk(dn_req && dn_we && dn_lock && !up_ready, "R5 write phase", {28'b0, dn_req, dn_we, dn_lock, up_ready}, 32'hE);
        chk(dn_wdata === 32'h0234_567B, "R6 merged word", dn_wdata, 32'h0234_567B);
        chk(dn_addr === 32'h2000_0004, "R5 write addr", dn_addr, 32'h2000_0004);
        @(negedge clk); #1;
        chk(up_ready && !dn_req && !dn_lock, "R5 finish", {29'b0, up_ready, dn_req, dn_lock}, 32'h4);
        // R10 back-to-back pass-through read
        @(negedge clk);
        up_we = 1'b0; up_addr = 32'h2000_0004; up_wdata = 32'h0;
        #1;
        chk(up_ready && dn_req && !dn_we && !dn_lock, "R10 accept", {28'b0, up_ready, dn_req, dn_we, dn_lock}, 32'hC);
        chk(up_rdata === 32'h0234_567B, "R10 R1 data", up_rdata, 32'h0234_567B);
        chk(dn_addr === 32'h2000_0004, "R1 addr copy", dn_addr, 32'h2000_0004);
        // R8 non-CPU pass-through write, same cycle
        @(negedge clk);
        up_master = 2'd3; up_we = 1'b1; up_addr = 32'h0800_0040; up_wdata = 32'hCAFE_0001;
        #1;
        chk(up_ready && dn_req && dn_we && !up_err, "R8 pass", {28'b0, up_ready, dn_req, dn_we, up_err}, 32'hE);
        chk(dn_wdata === 32'hCAFE_0001, "R8 wdata", dn_wdata, 32'hCAFE_0001);
        @(posedge clk); #1 up_req = 1'b0;
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule